// File: doc/BRIEF.md
# Thermometer Ramp Cell-Enable Generator

This block drives the on/off control of every unit current cell in a rectangular array, so that a current-steering ramp rises by exactly one cell per step. The array is thermometer coded throughout, with no binary segment. One column shift register is shared by all rows. A row shift register marks which rows are complete and which row is being filled. A per-row decode combines the two.

The column register fills with ones on even-indexed rows and with zeros on odd-indexed rows. The odd rows read the column bits inverted, so the register never has to be cleared between rows. Cell index is `row*COLS + col`. The active set is therefore always a contiguous run of the lowest indices.

A ramp is armed by a start pulse that may pre-enable a number of spare cells, which sets the ramp offset. Each accepted step then adds one cell. Two ramps per readout, as in digital double sampling, are made by issuing start twice. A step counter and a done flag let the sequencer end the conversion at a programmable count. Once every cell is on, the generator holds.

Top module: `ramp_therm_gen`

## Requirements
- R1: After reset, or one cycle after `clear_i`, no cell is enabled, `step_cnt_o` is 0 and `done_o` is low.
- R2: While the generator is not armed (after reset or clear, before any start), `step_i` changes neither the enables nor the step count.
- R3: One cycle after `start_i`, exactly the cells with index below min(`preload_i`, COLS*ROWS) are enabled and `step_cnt_o` is 0.
- R4: Each accepted step (armed, not all cells on, `step_i` high, no start or clear) enables exactly one more cell one cycle later, disables none, and increments `step_cnt_o` by one.
- R5: The enable vector is always a thermometer code over the cell index `row*COLS + col` (bit 0 is row 0, column 0). Each row fills from column 0 upward, and rows fill in ascending order.
- R6: In a cycle with `step_i`, `start_i` and `clear_i` all low, the enables and the step count do not change.
- R7: Once all COLS*ROWS cells are enabled, further steps are ignored and the step count stops.
- R8: `done_o` is high exactly while `step_cnt_o` is at least DONE_STEPS (default 4096).
- R9: `clear_i` takes priority over `start_i`, and `start_i` takes priority over `step_i`, when they are asserted in the same cycle.
- R10: A start issued in the middle of a ramp restarts it from the new preload, with the step count returned to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Advance the ramp by one cell |
| start_i | input | 1 | Arm a new ramp and load the preload count |
| clear_i | input | 1 | Synchronous ramp reset: all cells off, disarmed |
| preload_i | input | $clog2(COLS*ROWS+1) | Number of cells enabled at start (clamped) |
| cell_en_o | output | COLS*ROWS | Cell enables, bit index row*COLS+col |
| step_cnt_o | output | $clog2(COLS*ROWS+1) | Accepted steps since the last start |
| done_o | output | 1 | Step count has reached DONE_STEPS |

## Verification
Suppose the fill polarity goes wrong or the column position is stale. The fault shows at the first row boundary: on the step that wraps, the enable vector stops being a thermometer code, or its population jumps by more or less than one. In a reduced array, a sweep of every preload value with stepped, gapped and saturating sequences reaches every row boundary and the saturation point within a few dozen cycles. Each output is compared every cycle against a thermometer of length preload plus steps.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  typedef enum logic {
    POL_ZEROS = 1'b0,
    POL_ONES  = 1'b1
  } fill_e;
endpackage

// File: rtl/ramp_col_sreg.sv
module ramp_col_sreg
  import ramp_pkg::*;
#(
  parameter int COLS = 100,
  localparam int PW = $clog2(COLS)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic            load_i,
  input  logic [PW-1:0]   load_pos_i,
  input  fill_e           load_fill_i,
  input  logic            shift_i,
  input  fill_e           fill_i,
  output logic [COLS-1:0] col_o
);
  logic [COLS-1:0] col_q;
  logic [COLS-1:0] load_vec;

  // bits below the position already carry this row's fill value
  for (genvar j = 0; j < COLS; j++) begin : g_ld
    assign load_vec[j] = (PW'(j) < load_pos_i) ? load_fill_i : ~load_fill_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      col_q <= '0;
    else if (clr_i)   col_q <= '0;
    else if (load_i)  col_q <= load_vec;
    else if (shift_i) col_q <= {col_q[COLS-2:0], logic'(fill_i)};
  end

  assign col_o = col_q;
endmodule

// File: rtl/ramp_row_sreg.sv
module ramp_row_sreg #(
  parameter int ROWS = 50,
  localparam int RW = $clog2(ROWS+1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          load_i,
  input  logic [RW-1:0] load_row_i,
  input  logic          shift_i,
  output logic [ROWS:0] row_o
);
  logic [ROWS:0] row_q;
  logic [ROWS:0] load_vec;

  // bit n set: row n started; bit n+1 set: row n complete
  for (genvar n = 0; n <= ROWS; n++) begin : g_ld
    assign load_vec[n] = (RW'(n) <= load_row_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      row_q <= '0;
    else if (clr_i)   row_q <= '0;
    else if (load_i)  row_q <= load_vec;
    else if (shift_i) row_q <= {row_q[ROWS-1:0], 1'b1};
  end

  assign row_o = row_q;
endmodule

// File: rtl/ramp_row_decode.sv
module ramp_row_decode #(
  parameter int COLS = 100,
  parameter int ROWS = 50,
  localparam int CELLS = COLS*ROWS
) (
  input  logic [ROWS:0]    row_i,
  input  logic [COLS-1:0]  col_i,
  output logic [CELLS-1:0] cell_o
);
  for (genvar n = 0; n < ROWS; n++) begin : g_row
    logic cur;
    assign cur = row_i[n] & ~row_i[n+1];
    if (n % 2 == 0) begin : g_fwd
      assign cell_o[n*COLS +: COLS] = row_i[n+1] ? {COLS{1'b1}} : (cur ? col_i : '0);
    end else begin : g_inv
      assign cell_o[n*COLS +: COLS] = row_i[n+1] ? {COLS{1'b1}} : (cur ? ~col_i : '0);
    end
  end
endmodule

// File: rtl/ramp_therm_gen.sv
module ramp_therm_gen
  import ramp_pkg::*;
#(
  parameter int COLS       = 100,
  parameter int ROWS       = 50,
  parameter int DONE_STEPS = 4096,
  localparam int CELLS = COLS*ROWS,
  localparam int CW    = $clog2(CELLS+1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             start_i,
  input  logic             clear_i,
  input  logic [CW-1:0]    preload_i,
  output logic [CELLS-1:0] cell_en_o,
  output logic [CW-1:0]    step_cnt_o,
  output logic             done_o
);
  localparam int PW = $clog2(COLS);
  localparam int RW = $clog2(ROWS+1);

  logic [ROWS:0]   row_q;
  logic [COLS-1:0] col_q;
  logic [PW-1:0]   col_pos_q;
  fill_e           fill_q;
  logic [CW-1:0]   step_cnt_q;

  logic          armed, full, load, step_ok, wrap;
  logic [CW-1:0] pre_cl;
  logic [RW-1:0] pre_row;
  logic [PW-1:0] pre_pos;
  fill_e         pre_fill;

  assign pre_cl   = (preload_i > CW'(CELLS)) ? CW'(CELLS) : preload_i;
  assign pre_row  = RW'(pre_cl / CW'(COLS));
  assign pre_pos  = PW'(pre_cl % CW'(COLS));
  assign pre_fill = pre_row[0] ? POL_ZEROS : POL_ONES;

  assign armed   = row_q[0];
  assign full    = row_q[ROWS];
  assign load    = start_i & ~clear_i;
  assign step_ok = step_i & ~clear_i & ~start_i & armed & ~full;
  assign wrap    = step_ok & (col_pos_q == PW'(COLS-1));

  ramp_col_sreg #(.COLS(COLS)) u_col (
    .clk_i, .rst_ni,
    .clr_i       (clear_i),
    .load_i      (load),
    .load_pos_i  (pre_pos),
    .load_fill_i (pre_fill),
    .shift_i     (step_ok),
    .fill_i      (fill_q),
    .col_o       (col_q)
  );

  ramp_row_sreg #(.ROWS(ROWS)) u_row (
    .clk_i, .rst_ni,
    .clr_i      (clear_i),
    .load_i     (load),
    .load_row_i (pre_row),
    .shift_i    (wrap),
    .row_o      (row_q)
  );

  ramp_row_decode #(.COLS(COLS), .ROWS(ROWS)) u_dec (
    .row_i  (row_q),
    .col_i  (col_q),
    .cell_o (cell_en_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_pos_q  <= '0;
      fill_q     <= POL_ONES;
      step_cnt_q <= '0;
    end else if (clear_i) begin
      col_pos_q  <= '0;
      fill_q     <= POL_ONES;
      step_cnt_q <= '0;
    end else if (load) begin
      col_pos_q  <= pre_pos;
      fill_q     <= pre_fill;
      step_cnt_q <= '0;
    end else if (step_ok) begin
      step_cnt_q <= step_cnt_q + 1'b1;
      if (wrap) begin
        col_pos_q <= '0;
        fill_q    <= (fill_q == POL_ONES) ? POL_ZEROS : POL_ONES;
      end else begin
        col_pos_q <= col_pos_q + 1'b1;
      end
    end
  end

  assign step_cnt_o = step_cnt_q;
  assign done_o     = (32'(step_cnt_q) >= 32'(DONE_STEPS));
endmodule

// File: rtl/ramp_therm_gen_chk.sv
module ramp_therm_gen_chk #(
  parameter int COLS       = 100,
  parameter int ROWS       = 50,
  parameter int DONE_STEPS = 4096,
  localparam int CELLS = COLS*ROWS,
  localparam int CW    = $clog2(CELLS+1)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             step_i,
  input logic             start_i,
  input logic             clear_i,
  input logic [CW-1:0]    preload_i,
  input logic [CELLS-1:0] cell_en_o,
  input logic [CW-1:0]    step_cnt_o,
  input logic             done_o,
  input logic             armed,
  input logic             full
);
  logic [CW-1:0] pre_sh;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pre_sh <= '0;
    else if (start_i && !clear_i)
      pre_sh <= (preload_i > CW'(CELLS)) ? CW'(CELLS) : preload_i;
  end

  // R1
  clear_state_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clear_i |=> (cell_en_o == '0) && (step_cnt_o == '0) && !done_o);

  // R3
  load_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i && !clear_i |=> ($countones(cell_en_o) == int'(pre_sh)) && (step_cnt_o == '0));

  // R4
  one_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !start_i && !clear_i && armed && !full |=>
      ($countones(cell_en_o) == $countones($past(cell_en_o)) + 1) &&
      ((cell_en_o & $past(cell_en_o)) == $past(cell_en_o)));

  // R5
  therm_shape_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cell_en_o & (cell_en_o + 1'b1)) == '0);

  // R5
  pop_track_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    armed |-> $countones(cell_en_o) == int'(pre_sh) + int'(step_cnt_o));

  // R2 R6 R7
  no_move_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !start_i && !clear_i && (!step_i || !armed || full) |=>
      $stable(cell_en_o) && $stable(step_cnt_o));

  // R8
  done_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(done_o) |-> 32'(step_cnt_o) == 32'(DONE_STEPS));
endmodule

bind ramp_therm_gen ramp_therm_gen_chk #(
  .COLS(COLS), .ROWS(ROWS), .DONE_STEPS(DONE_STEPS)
) u_chk (.*);

// File: tb/ramp_therm_gen_tb.sv
module ramp_therm_gen_tb;
  localparam int COLS  = 4;
  localparam int ROWS  = 3;
  localparam int DS    = 5;
  localparam int CELLS = COLS*ROWS;
  localparam int CW    = $clog2(CELLS+1);

  logic             clk_i = 1'b0;
  logic             rst_ni = 1'b0;
  logic             step_i = 1'b0, start_i = 1'b0, clear_i = 1'b0;
  logic [CW-1:0]    preload_i = '0;
  logic [CELLS-1:0] cell_en_o;
  logic [CW-1:0]    step_cnt_o;
  logic             done_o;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk_i = ~clk_i;

  ramp_therm_gen #(.COLS(COLS), .ROWS(ROWS), .DONE_STEPS(DS)) u_dut (.*);

  function automatic logic [CELLS-1:0] therm(int n);
    logic [CELLS-1:0] v;
    for (int i = 0; i < CELLS; i++) v[i] = (i < n);
    return v;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic chk_all(input string req, input int on, input int cnt);
    chk(cell_en_o == therm(on), req, "cell_en", longint'(cell_en_o), longint'(therm(on)));
    chk(32'(step_cnt_o) == cnt, req, "step_cnt", longint'(step_cnt_o), cnt);
    chk(done_o == (cnt >= DS), req, "done", done_o, (cnt >= DS));
  endtask

  task automatic cyc(input logic st, input logic stp, input logic clr, input int pre);
    start_i = st; step_i = stp; clear_i = clr; preload_i = CW'(pre);
    @(negedge clk_i);
    start_i = 0; step_i = 0; clear_i = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk_all("R1", 0, 0);

    // R2: steps before any start are ignored
    repeat (3) cyc(0, 1, 0, 0);
    chk_all("R2", 0, 0);

    // exhaustive preload sweep with gapped and saturating steps
    for (int p = 0; p < (1 << CW); p++) begin
      int pm;
      int s;
      pm = (p > CELLS) ? CELLS : p;
      s = 0;
      cyc(1, 0, 0, p);
      chk_all("R3", pm, 0);
      for (int c = 0; c < 2*CELLS + 4; c++) begin
        bit stp;
        bit acc;
        stp = (c % 3 != 2);
        acc = stp && (pm + s < CELLS);
        cyc(0, stp, 0, 0);
        if (acc) s++;
        if (!stp)            chk_all("R6", pm + s, s);
        else if (!acc)       chk_all("R7", pm + s, s);
        else if (s >= DS)    chk_all("R8", pm + s, s);
        else                 chk_all("R4/R5", pm + s, s);
      end
    end

    // R1: clear mid-ramp
    cyc(1, 0, 0, 2);
    cyc(0, 1, 0, 0);
    cyc(0, 0, 1, 0);
    chk_all("R1", 0, 0);
    cyc(0, 1, 0, 0);
    chk_all("R2", 0, 0);

    // R9: clear beats start and step
    cyc(1, 0, 0, 3);
    cyc(1, 1, 1, 7);
    chk_all("R9", 0, 0);
    // R9: start beats step
    cyc(1, 1, 0, 6);
    chk_all("R9", 6, 0);

    // R10: restart mid-ramp with new preload
    repeat (3) cyc(0, 1, 0, 0);
    chk_all("R4", 9, 3);
    cyc(1, 0, 0, 1);
    chk_all("R10", 1, 0);
    cyc(0, 1, 0, 0);
    chk_all("R10", 2, 1);

    // R8: done reached exactly at DS, held until start
    for (int k = 2; k <= DS; k++) begin
      cyc(0, 1, 0, 0);
      chk_all("R8", 1 + k, k);
    end
    cyc(0, 0, 0, 0);
    chk_all("R8", 1 + DS, DS);
    cyc(1, 0, 0, 0);
    chk_all("R8", 0, 0);

    finished = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end
endmodule